// File: doc/BRIEF.md
# Programmable Single/Double Pulse Sequencer

The block turns one base clock into a timed pulse stream. Every timing quantity is a count of base-clock ticks: a repetition period, a pulse width, a delay from the start of each period to the first pulse, and a spacing from the first pulse to an optional second pulse. A selectable trigger starts the stream. The trigger can be a software run bit or one of two external inputs, on a rising or falling edge. The stream then runs continuously, for a programmed number of periods, or, in follow mode, copies the chosen trigger level straight to the output.

An optional gate input masks the output while the gate is low. A sticky end-of-burst flag reports that a counted run has finished. New timing values are taken into internal shadow registers only when a period starts, so a write in the middle of a sequence never distorts the pulse that is in progress. All three external levels, the software bit included, pass through the same two-flop synchronizer, so every trigger source has the same latency.

Top module: `pulse_seq_gen`

## Requirements
- R1: After reset `pulse_out` and `eob` are 0 and the sequencer is idle.
- R2: `trig_sel[2:0]` picks the start source: 000 is `sw_run`, 001 is `trig_a`, 010 is `trig_b`, and any other value starts nothing. `trig_sel[3]`=1 selects the falling edge instead of the rising edge. If the edge reaches the inputs before clock edge k, tick 0 of the first period is visible after edge k+2.
- R3: Within a period, the tick t runs from 0 to P-1. The output is high for D <= t < D+W and, when `double_en`=1, also for D+S <= t < D+S+W.
- R4: In continuous mode (`run_mode` 00 or 11), periods repeat back to back until `enable` falls.
- R5: In burst mode (`run_mode`=01), the block emits `burst_cnt` periods, where a count of 0 acts as 1. It then goes idle, sets `eob` on the edge that ends the last period, and a later trigger starts a new burst.
- R6: `eob` stays at 1 until a cycle with `eob_clr`=1 clears it.
- R7: A period below 2 acts as 2. A width of P or more acts as P-1.
- R8: Period, width, delay, spacing and `double_en` are sampled only when a period starts. Changes made during a period take effect from the next period.
- R9: In follow mode (`run_mode`=10), `pulse_out` equals the synchronized selected level, inverted when `trig_sel[3]`=1. A change before edge k shows after edge k+1.
- R10: With `gate_en`=1, `pulse_out` is 0 while the synchronized `gate_in` is 0.
- R11: `enable`=0 drives `pulse_out` low at once and idles the sequencer on the next edge. Triggers seen while disabled are lost.
- R12: A trigger that arrives while a sequence is running has no effect. No start is queued for later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Master enable |
| run_mode | input | 2 | 00/11 continuous, 01 burst, 10 follow |
| trig_sel | input | 4 | Start source and edge code |
| sw_run | input | 1 | Software run bit |
| trig_a | input | 1 | External trigger A |
| trig_b | input | 1 | External trigger B |
| gate_in | input | 1 | External gate, active high |
| gate_en | input | 1 | Apply the gate |
| double_en | input | 1 | Emit a second pulse per period |
| period | input | CNT_W | Period in ticks |
| width | input | CNT_W | Pulse width in ticks |
| delay | input | CNT_W | Period start to first pulse |
| spacing | input | CNT_W | First pulse start to second pulse start |
| burst_cnt | input | BURST_W | Periods per burst |
| eob_clr | input | 1 | Clear end-of-burst flag |
| pulse_out | output | 1 | Pulse stream |
| eob | output | 1 | End-of-burst flag |

## Verification
A tick counter that is off by one moves every pulse edge. That error appears within the first period as a high cycle one sample early or late against the tick pattern the bench computes. Shadow registers that load at the wrong moment change the pulse shape inside the period in which the write happens, not at the next period. A burst counter that is out by one moves the rise of `eob`, and the output goes quiet one full period early or late. Broken edge selection or a broken retrigger lockout shows up as an unexpected start or a missing start within three cycles of the stimulus.

// File: rtl/pgen_pkg.sv
package pgen_pkg;
  typedef enum logic [1:0] {
    MODE_CONT     = 2'd0,
    MODE_BURST    = 2'd1,
    MODE_FOLLOW   = 2'd2,
    MODE_CONT_ALT = 2'd3
  } run_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;

  localparam logic [2:0] SRC_SW = 3'd0;
  localparam logic [2:0] SRC_A  = 3'd1;
  localparam logic [2:0] SRC_B  = 3'd2;
endpackage

// File: rtl/pgen_sync.sv
module pgen_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int NST = (STAGES < 2) ? 2 : STAGES;
  logic [NST-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < NST; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[NST-1];
endmodule

// File: rtl/pgen_trig.sv
module pgen_trig #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_run,
  input  logic       trig_a,
  input  logic       trig_b,
  input  logic       gate_in,
  input  logic [3:0] trig_sel,
  output logic       trig_evt,
  output logic       follow_lvl,
  output logic       gate_lvl
);
  import pgen_pkg::*;

  logic [3:0] raw_lv, syn_lv;
  logic       sel_lvl, sel_ok, sel_prev, use_fall;

  assign raw_lv = {gate_in, trig_b, trig_a, sw_run};

  pgen_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_lv), .q(syn_lv)
  );

  always_comb begin
    sel_ok  = 1'b1;
    sel_lvl = 1'b0;
    case (trig_sel[2:0])
      SRC_SW:  sel_lvl = syn_lv[0];
      SRC_A:   sel_lvl = syn_lv[1];
      SRC_B:   sel_lvl = syn_lv[2];
      default: sel_ok  = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_prev <= 1'b0;
    else        sel_prev <= sel_lvl;
  end

  assign use_fall   = trig_sel[3];
  assign trig_evt   = sel_ok & (use_fall ? (~sel_lvl & sel_prev) : (sel_lvl & ~sel_prev));
  assign follow_lvl = sel_ok & (sel_lvl ^ use_fall);
  assign gate_lvl   = syn_lv[3];

  AST_EVT_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_evt && $stable(trig_sel) |=> !trig_evt || !$stable(trig_sel)); // R2

  AST_RESERVED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_sel[2:0] > SRC_B) |-> !trig_evt && !follow_lvl); // R2
endmodule

// File: rtl/pgen_seq.sv
module pgen_seq #(
  parameter int CNT_W   = 40,
  parameter int BURST_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [1:0]         run_mode,
  input  logic               trig_evt,
  input  logic [CNT_W-1:0]   period,
  input  logic [CNT_W-1:0]   width,
  input  logic [CNT_W-1:0]   delay,
  input  logic [CNT_W-1:0]   spacing,
  input  logic               double_en,
  input  logic [BURST_W-1:0] burst_cnt,
  input  logic               eob_clr,
  output logic               seq_win,
  output logic               eob,
  output logic               busy
);
  import pgen_pkg::*;

  localparam int XW = CNT_W + 2;

  function automatic logic [CNT_W-1:0] eff_period(input logic [CNT_W-1:0] p);
    return (p < CNT_W'(2)) ? CNT_W'(2) : p;
  endfunction

  function automatic logic [CNT_W-1:0] eff_width(input logic [CNT_W-1:0] w,
                                                 input logic [CNT_W-1:0] ep);
    return (w >= ep) ? ep - CNT_W'(1) : w;
  endfunction

  function automatic logic in_win(input logic [CNT_W-1:0] t,
                                  input logic [XW-1:0]    start,
                                  input logic [CNT_W-1:0] w);
    logic [XW-1:0] tx;
    tx = {2'b00, t};
    return (tx >= start) && (tx < start + {2'b00, w});
  endfunction

  seq_state_e         state;
  logic [CNT_W-1:0]   tick, sh_period, sh_width, sh_delay, sh_space;
  logic               sh_double, is_burst, eob_q;
  logic [BURST_W-1:0] remain;
  logic               live, seq_end, last_seq, eob_set, start_seq;
  logic [CNT_W-1:0]   new_period;

  assign live       = enable && (run_mode != MODE_FOLLOW);
  assign busy       = (state == ST_RUN);
  assign seq_end    = busy && (tick == sh_period - CNT_W'(1));
  assign last_seq   = is_burst && (remain == BURST_W'(1));
  assign eob_set    = live && seq_end && last_seq;
  assign start_seq  = live && !busy && trig_evt;
  assign new_period = eff_period(period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      tick      <= '0;
      sh_period <= CNT_W'(2);
      sh_width  <= '0;
      sh_delay  <= '0;
      sh_space  <= '0;
      sh_double <= 1'b0;
      is_burst  <= 1'b0;
      remain    <= '0;
    end else if (!live) begin
      state <= ST_IDLE;
      tick  <= '0;
    end else if (start_seq || seq_end) begin
      tick      <= '0;
      sh_period <= new_period;
      sh_width  <= eff_width(width, new_period);
      sh_delay  <= delay;
      sh_space  <= spacing;
      sh_double <= double_en;
      if (start_seq) begin
        state    <= ST_RUN;
        is_burst <= (run_mode == MODE_BURST);
        remain   <= (burst_cnt == '0) ? BURST_W'(1) : burst_cnt;
      end else if (is_burst) begin
        if (last_seq) state <= ST_IDLE;
        else          remain <= remain - BURST_W'(1);
      end
    end else if (busy) begin
      tick <= tick + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       eob_q <= 1'b0;
    else if (eob_set) eob_q <= 1'b1;
    else if (eob_clr) eob_q <= 1'b0;
  end

  assign eob     = eob_q;
  assign seq_win = busy && (in_win(tick, {2'b00, sh_delay}, sh_width) ||
                   (sh_double && in_win(tick, {2'b00, sh_delay} + {2'b00, sh_space}, sh_width)));

  AST_TICK_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> tick < sh_period); // R7

  AST_LOW_AT_PERIOD_END: assert property (@(posedge clk) disable iff (!rst_n)
    seq_end && sh_delay == '0 && !sh_double |-> !seq_win); // R7

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !seq_end && live |=> $stable(sh_width) && $stable(sh_delay) && $stable(sh_period)); // R8

  AST_DISABLE_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !busy); // R11

  AST_EOB_FROM_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eob_q) |-> $past(busy) && $past(is_burst) && !busy); // R5

  AST_NO_RESTART_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !seq_end && live |=> busy && tick == $past(tick) + CNT_W'(1)); // R12
endmodule

// File: rtl/pulse_seq_gen.sv
module pulse_seq_gen #(
  parameter int CNT_W       = 40,
  parameter int BURST_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [1:0]         run_mode,
  input  logic [3:0]         trig_sel,
  input  logic               sw_run,
  input  logic               trig_a,
  input  logic               trig_b,
  input  logic               gate_in,
  input  logic               gate_en,
  input  logic               double_en,
  input  logic [CNT_W-1:0]   period,
  input  logic [CNT_W-1:0]   width,
  input  logic [CNT_W-1:0]   delay,
  input  logic [CNT_W-1:0]   spacing,
  input  logic [BURST_W-1:0] burst_cnt,
  input  logic               eob_clr,
  output logic               pulse_out,
  output logic               eob
);
  import pgen_pkg::*;

  logic trig_evt, follow_lvl, gate_lvl, seq_win, busy, gate_ok, follow_on;

  pgen_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk(clk), .rst_n(rst_n), .sw_run(sw_run), .trig_a(trig_a), .trig_b(trig_b),
    .gate_in(gate_in), .trig_sel(trig_sel), .trig_evt(trig_evt),
    .follow_lvl(follow_lvl), .gate_lvl(gate_lvl)
  );

  pgen_seq #(.CNT_W(CNT_W), .BURST_W(BURST_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .run_mode(run_mode), .trig_evt(trig_evt),
    .period(period), .width(width), .delay(delay), .spacing(spacing),
    .double_en(double_en), .burst_cnt(burst_cnt), .eob_clr(eob_clr),
    .seq_win(seq_win), .eob(eob), .busy(busy)
  );

  assign follow_on = (run_mode == MODE_FOLLOW);
  assign gate_ok   = !gate_en || gate_lvl;
  assign pulse_out = enable && gate_ok && (follow_on ? follow_lvl : seq_win);

  AST_FOLLOW_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    follow_on |=> !busy || !follow_on); // R9

  AST_GATE_MASKS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    gate_en && !gate_lvl && busy |-> !pulse_out); // R10
endmodule

// File: tb/sim_pulse_seq_gen.sv
module sim_pulse_seq_gen;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        enable = 1'b1, sw_run = 1'b0, trig_a = 1'b0, trig_b = 1'b0;
  logic        gate_in = 1'b0, gate_en = 1'b0, double_en = 1'b0, eob_clr = 1'b0;
  logic [1:0]  run_mode = 2'b01;
  logic [3:0]  trig_sel = 4'b0001;
  logic [39:0] period = 40'd10, width = 40'd1, delay = 40'd0, spacing = 40'd0;
  logic [15:0] burst_cnt = 16'd1;
  logic        pulse_out, eob;
  int          nchk = 0, nerr = 0;
  bit          done = 1'b0;

  pulse_seq_gen u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .run_mode(run_mode), .trig_sel(trig_sel),
    .sw_run(sw_run), .trig_a(trig_a), .trig_b(trig_b), .gate_in(gate_in), .gate_en(gate_en),
    .double_en(double_en), .period(period), .width(width), .delay(delay), .spacing(spacing),
    .burst_cnt(burst_cnt), .eob_clr(eob_clr), .pulse_out(pulse_out), .eob(eob)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Level expected at tick n of a run, restated from R3 and R7.
  function automatic bit exp_level(longint n, longint P, longint D, longint W, longint S, bit dbl);
    longint pe, we, ph;
    pe = (P > 1) ? P : 2;
    we = (W < pe) ? W : pe - 1;
    ph = n % pe;
    if (ph - D >= 0 && ph - D < we) return 1'b1;
    if (dbl && ph - D - S >= 0 && ph - D - S < we) return 1'b1;
    return 1'b0;
  endfunction

  task automatic set_timing(input longint P, input longint D, input longint W, input longint S);
    period = 40'(P); delay = 40'(D); width = 40'(W); spacing = 40'(S);
  endtask

  // Call right after driving the start edge at a negedge.
  task automatic expect_seq(input string req, input int cnt, input longint P, input longint D,
                            input longint W, input longint S, input bit dbl);
    repeat (3) @(posedge clk);
    for (int n = 0; n < cnt; n++) begin
      @(negedge clk);
      chk(req, pulse_out, exp_level(n, P, D, W, S, dbl));
    end
  endtask

  task automatic expect_quiet(input string req, input int cnt);
    for (int n = 0; n < cnt; n++) begin
      @(negedge clk);
      chk(req, pulse_out, 1'b0);
    end
  endtask

  task automatic clear_eob();
    @(negedge clk) eob_clr = 1'b1;
    @(negedge clk) eob_clr = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 out", pulse_out, 1'b0);
    chk("R1 eob", eob, 1'b0);
  endtask

  task automatic t_single_burst();
    run_mode = 2'b01; trig_sel = 4'b0001; burst_cnt = 16'd1; double_en = 1'b0;
    set_timing(10, 2, 3, 0);
    repeat (4) @(negedge clk);
    trig_a = 1'b1;
    expect_seq("R3 single", 10, 10, 2, 3, 0, 1'b0);
    @(negedge clk);
    chk("R5 idle after burst", pulse_out, 1'b0);
    chk("R5 eob set", eob, 1'b1);
    trig_a = 1'b0;
  endtask

  task automatic t_eob_clear();
    repeat (5) @(negedge clk);
    chk("R6 eob held", eob, 1'b1);
    clear_eob();
    chk("R6 eob cleared", eob, 1'b0);
  endtask

  task automatic t_double_burst();
    trig_b = 1'b1; trig_sel = 4'b1010; run_mode = 2'b01; burst_cnt = 16'd3; double_en = 1'b1;
    set_timing(12, 1, 2, 5);
    repeat (4) @(negedge clk);
    trig_b = 1'b0;
    expect_seq("R3 double burst", 36, 12, 1, 2, 5, 1'b1);
    @(negedge clk);
    chk("R5 burst of three ends", pulse_out, 1'b0);
    chk("R5 eob after three", eob, 1'b1);
    clear_eob();
    trig_b = 1'b1;
    double_en = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_clamp();
    trig_sel = 4'b0001; run_mode = 2'b01; burst_cnt = 16'd0;
    set_timing(1, 0, 1, 0);
    repeat (4) @(negedge clk);
    trig_a = 1'b1;
    expect_seq("R7 period floor", 2, 1, 0, 1, 0, 1'b0);
    @(negedge clk);
    chk("R5 zero count acts as one", eob, 1'b1);
    clear_eob();
    trig_a = 1'b0;
    burst_cnt = 16'd1;
    set_timing(5, 0, 9, 0);
    repeat (4) @(negedge clk);
    trig_a = 1'b1;
    expect_seq("R7 width clamp", 5, 5, 0, 9, 0, 1'b0);
    @(negedge clk);
    chk("R7 low after clamp", pulse_out, 1'b0);
    clear_eob();
    trig_a = 1'b0;
  endtask

  task automatic t_continuous_sw();
    run_mode = 2'b00; trig_sel = 4'b0000;
    set_timing(6, 0, 2, 0);
    repeat (4) @(negedge clk);
    sw_run = 1'b1;
    expect_seq("R4 continuous", 19, 6, 0, 2, 0, 1'b0);
    @(negedge clk);
    enable = 1'b0;
    #1 chk("R11 immediate low", pulse_out, 1'b0);
    sw_run = 1'b0;
    repeat (3) @(negedge clk);
    enable = 1'b1;
    expect_quiet("R11 idle after disable", 12);
    chk("R4 no eob in continuous", eob, 1'b0);
  endtask

  task automatic t_boundary_update();
    run_mode = 2'b00; trig_sel = 4'b0001;
    set_timing(10, 0, 2, 0);
    repeat (4) @(negedge clk);
    trig_a = 1'b1;
    repeat (3) @(posedge clk);
    for (int n = 0; n < 30; n++) begin
      @(negedge clk);
      chk("R8 boundary update", pulse_out, exp_level(n, 10, 0, (n < 10) ? 2 : 5, 0, 1'b0));
      if (n == 3) width = 40'd5;
    end
    enable = 1'b0;
    trig_a = 1'b0;
    repeat (4) @(negedge clk);
    enable = 1'b1;
  endtask

  task automatic t_follow();
    run_mode = 2'b10; trig_sel = 4'b0001; trig_a = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 follow low", pulse_out, 1'b0);
    trig_a = 1'b1;
    @(negedge clk);
    chk("R9 follow latency", pulse_out, 1'b0);
    @(negedge clk);
    chk("R9 follow high", pulse_out, 1'b1);
    trig_sel = 4'b1001;
    #1 chk("R9 follow inverted", pulse_out, 1'b0);
    @(negedge clk);
    trig_a = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 inverted follows low input", pulse_out, 1'b1);
    trig_sel = 4'b0001;
    run_mode = 2'b01;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_gate();
    int ones;
    run_mode = 2'b00; trig_sel = 4'b0001; gate_en = 1'b1; gate_in = 1'b0;
    set_timing(4, 0, 2, 0);
    repeat (4) @(negedge clk);
    trig_a = 1'b1;
    repeat (3) @(posedge clk);
    expect_quiet("R10 gate closed", 12);
    @(negedge clk);
    gate_in = 1'b1;
    repeat (2) @(posedge clk);
    ones = 0;
    for (int n = 0; n < 8; n++) begin
      @(negedge clk);
      if (pulse_out) ones++;
    end
    nchk++;
    if (ones != 4) begin
      nerr++;
      $display("FAIL R10 gate open: actual %0d high cycles expected 4", ones);
    end
    enable = 1'b0; gate_en = 1'b0; gate_in = 1'b0; trig_a = 1'b0;
    repeat (4) @(negedge clk);
    enable = 1'b1;
  endtask

  task automatic t_retrigger();
    run_mode = 2'b01; trig_sel = 4'b0001; burst_cnt = 16'd1;
    set_timing(20, 0, 3, 0);
    repeat (4) @(negedge clk);
    trig_a = 1'b1;
    repeat (3) @(posedge clk);
    for (int n = 0; n < 27; n++) begin
      @(negedge clk);
      chk("R12 retrigger ignored", pulse_out, (n < 20) ? exp_level(n, 20, 0, 3, 0, 1'b0) : 1'b0);
      if (n == 5) trig_a = 1'b0;
      if (n == 8) trig_a = 1'b1;
    end
    clear_eob();
    trig_a = 1'b0;
  endtask

  task automatic t_reserved_code();
    trig_sel = 4'b0011; run_mode = 2'b01;
    repeat (4) @(negedge clk);
    trig_a = 1'b1;
    expect_quiet("R2 reserved source", 20);
    chk("R2 reserved no eob", eob, 1'b0);
    trig_a = 1'b0;
    trig_sel = 4'b0001;
  endtask

  task automatic t_disabled_trigger();
    set_timing(6, 0, 3, 0);
    repeat (4) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    trig_a = 1'b1;
    repeat (6) @(negedge clk);
    enable = 1'b1;
    expect_quiet("R11 trigger while disabled lost", 15);
    trig_a = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_single_burst();
    t_eob_clear();
    t_double_burst();
    t_clamp();
    t_continuous_sw();
    t_boundary_update();
    t_follow();
    t_gate();
    t_retrigger();
    t_reserved_code();
    t_disabled_trigger();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule